// File: doc/BRIEF.md
# Dual-Loop Phase-Frequency Detector with Pump Control

This block holds two independent phase-frequency detectors, one per synthesizer loop (loop 0 and loop 1). Each compares a reference-divider pulse with a feedback-divider pulse. From that comparison it drives up/down enables, a high-impedance request and a current-level select for an external charge pump. A mode bit swaps the up and down outputs to match the sign of the VCO tuning slope. Another bit tri-states the pump while the detector keeps running. A third bit picks high (4×) or low (1×) pump current. The new current level takes effect only while the detector is idle, so a pump pulse in progress never changes amplitude.

Each loop has a lock monitor. It declares lock after a programmable number of consecutive comparisons in which the detector stayed active for no more than `LOCK_WIN` clock cycles. One status output is shared by both loops. A 4-bit select chooses what it shows: lock detect, raw divider pulses, a fastlock ground switch, or counter-reset indications. Counter reset and powerdown both tri-state the affected loop and clear its detector and lock state. All pulses are sampled on one system clock; one divider pulse is one clock cycle high.

Top module: `dual_pfd_ctrl`

## Requirements
- R1: After a detector pulse arrives at the edge, the output of the leading input rises. It stays high until one edge after the lagging pulse arrives, so it is high for d+1 cycles when the lag is d cycles. The lagging output is high for exactly one cycle. Coincident pulses give one cycle on both. A second leading pulse before the lagging one keeps the leading output high.
- R2: With `pol_pos[i]`=1, a leading reference drives `pump_up[i]` and a leading feedback drives `pump_dn[i]`. With `pol_pos[i]`=0 the two are swapped.
- R3: `force_hiz[i]`=1 sets `pump_hiz[i]` and holds `pump_up[i]`/`pump_dn[i]` low. The detector state keeps evolving and reappears at the outputs when the bit clears.
- R4: `icp_high[i]` (1 = 4× current, 0 = 1× current) loads `cur_hi[i]` only at edges where loop i's detector is idle.
- R5: Loop i's lock is set once `lock_need` consecutive detector episodes each last at most `LOCK_WIN` cycles. An episode that goes beyond `LOCK_WIN` clears the count at once. Lock detect is high while locked and idle, and low during every active episode.
- R6: Status select codes: 0 low; 1 loop-0 lock; 2 loop-1 lock; 3 both locked (AND); 4 ref 0; 5 ref 1; 6 fb 0; 7 fb 1; 8 fastlock; 9 reset loop 0; 10 reset loop 1; 11 reset both; 12 to 15 low.
- R7: Code 3 reports lock only when both loops are locked.
- R8: Under code 8, with `icp_high[1]`=1, `fastlock_sw` is 1 and `stat_out` is 0 (switch to ground). Otherwise in code 8 `stat_out` is 1. Under any other code `fastlock_sw` is 0.
- R9: Codes 9, 10 and 11 tri-state the loops they name, drive `stat_out` low and clear those detectors. Pulses arriving meanwhile are discarded. Other loops are unaffected.
- R10: `pwrdn[i]` tri-states loop i and clears its detector and lock state. Lock detect for that loop is forced low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| ref_pls | input | 2 | reference-divider pulse per loop |
| fb_pls | input | 2 | feedback-divider pulse per loop |
| pol_pos | input | 2 | 1 = VCO frequency rises with tuning voltage |
| force_hiz | input | 2 | force pump high impedance |
| cur_hi | input | 2 | requested 4× pump current |
| pwrdn | input | 2 | loop powerdown |
| stat_sel | input | 4 | status output select code |
| lock_need | input | LCW | consecutive good comparisons for lock |
| pump_up | output | 2 | pump source enable |
| pump_dn | output | 2 | pump sink enable |
| pump_hiz | output | 2 | pump high-impedance enable |
| icp_high | output | 2 | applied current level (1 = 4×) |
| fastlock_sw | output | 1 | fastlock damping switch enable |
| stat_out | output | 1 | multiplexed status |

## Verification
A corrupted detector flip-flop shows up on `pump_up`/`pump_dn` at the very next edge. It appears as a wrong pulse width, since every width is a direct count of clock edges from the lead and lag pulses. A wrong width count or comparison count in the lock monitor does not show on the pump outputs. It shows only on `stat_out` under a lock code, one to two edges after an episode ends, so the bench checks lock status right after the threshold episode and right after an over-long one. A stale current-level register shows on `icp_high` and `fastlock_sw` one edge after the detector goes idle.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    localparam int NUM_LOOPS = 2;
    localparam int SEL_W     = 4;

    localparam logic [SEL_W-1:0] ST_OFF      = 4'd0;
    localparam logic [SEL_W-1:0] ST_LOCK0    = 4'd1;
    localparam logic [SEL_W-1:0] ST_LOCK1    = 4'd2;
    localparam logic [SEL_W-1:0] ST_LOCK_ALL = 4'd3;
    localparam logic [SEL_W-1:0] ST_REF0     = 4'd4;
    localparam logic [SEL_W-1:0] ST_REF1     = 4'd5;
    localparam logic [SEL_W-1:0] ST_FB0      = 4'd6;
    localparam logic [SEL_W-1:0] ST_FB1      = 4'd7;
    localparam logic [SEL_W-1:0] ST_FAST     = 4'd8;
    localparam logic [SEL_W-1:0] ST_RST0     = 4'd9;
    localparam logic [SEL_W-1:0] ST_RST1     = 4'd10;
    localparam logic [SEL_W-1:0] ST_RST_ALL  = 4'd11;

    typedef struct packed {
        logic up;
        logic dn;
    } pfd_state_t;

    // loops whose counters are held in reset by a status code
    function automatic logic [NUM_LOOPS-1:0] reset_mask(input logic [SEL_W-1:0] sel);
        logic [NUM_LOOPS-1:0] m;
        m[0] = (sel == ST_RST0) || (sel == ST_RST_ALL);
        m[1] = (sel == ST_RST1) || (sel == ST_RST_ALL);
        return m;
    endfunction
endpackage

// File: rtl/pfd_detector.sv
module pfd_detector
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       ref_p,
    input  logic       fb_p,
    output pfd_state_t st
);
    logic both;
    assign both = st.up & st.dn;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            st <= '0;
        end else begin
            st.up <= (st.up | ref_p) & ~both;
            st.dn <= (st.dn | fb_p) & ~both;
        end
    end
endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
    parameter int LOCK_WIN = 4,
    parameter int LCW      = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clear,
    input  logic           active,
    input  logic [LCW-1:0] need,
    output logic           locked
);
    localparam int WCW = $clog2(LOCK_WIN + 2);
    localparam logic [WCW-1:0] WMAX = WCW'(LOCK_WIN + 1);
    localparam logic [WCW-1:0] WLIM = WCW'(LOCK_WIN);
    localparam logic [LCW-1:0] GMAX = '1;

    logic [WCW-1:0] width_q;
    logic [LCW-1:0] good_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            width_q <= '0;
            good_q  <= '0;
        end else if (active) begin
            width_q <= (width_q == WMAX) ? width_q : width_q + 1'b1;
            if (width_q >= WLIM) good_q <= '0;
        end else begin
            width_q <= '0;
            if (width_q != '0) begin
                if (width_q <= WLIM)
                    good_q <= (good_q == GMAX) ? good_q : good_q + 1'b1;
                else
                    good_q <= '0;
            end
        end
    end

    assign locked = (good_q != '0) && (good_q >= need);
endmodule

// File: rtl/pfd_pump_ctrl.sv
module pfd_pump_ctrl
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pfd_state_t st,
    input  logic       pol_pos,
    input  logic       hiz_req,
    input  logic       cur_hi,
    output logic       up_o,
    output logic       dn_o,
    output logic       hiz_o,
    output logic       icp_o
);
    logic idle;
    assign idle  = ~(st.up | st.dn);
    assign hiz_o = hiz_req;
    assign up_o  = ~hiz_req & (pol_pos ? st.up : st.dn);
    assign dn_o  = ~hiz_req & (pol_pos ? st.dn : st.up);

    always_ff @(posedge clk) begin
        if (rst)       icp_o <= 1'b0;
        else if (idle) icp_o <= cur_hi;
    end
endmodule

// File: rtl/pfd_stat_mux.sv
module pfd_stat_mux
    import pfd_pkg::*;
(
    input  logic [SEL_W-1:0]     sel,
    input  logic [NUM_LOOPS-1:0] ld,
    input  logic [NUM_LOOPS-1:0] ref_p,
    input  logic [NUM_LOOPS-1:0] fb_p,
    input  logic                 fast_sw,
    output logic                 o
);
    always_comb begin
        case (sel)
            ST_LOCK0:    o = ld[0];
            ST_LOCK1:    o = ld[1];
            ST_LOCK_ALL: o = &ld;
            ST_REF0:     o = ref_p[0];
            ST_REF1:     o = ref_p[1];
            ST_FB0:      o = fb_p[0];
            ST_FB1:      o = fb_p[1];
            ST_FAST:     o = ~fast_sw;
            default:     o = 1'b0;
        endcase
    end
endmodule

// File: rtl/dual_pfd_ctrl.sv
module dual_pfd_ctrl
    import pfd_pkg::*;
#(
    parameter int LOCK_WIN = 4,
    parameter int LCW      = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LOOPS-1:0] ref_pls,
    input  logic [NUM_LOOPS-1:0] fb_pls,
    input  logic [NUM_LOOPS-1:0] pol_pos,
    input  logic [NUM_LOOPS-1:0] force_hiz,
    input  logic [NUM_LOOPS-1:0] cur_hi,
    input  logic [NUM_LOOPS-1:0] pwrdn,
    input  logic [SEL_W-1:0]     stat_sel,
    input  logic [LCW-1:0]       lock_need,
    output logic [NUM_LOOPS-1:0] pump_up,
    output logic [NUM_LOOPS-1:0] pump_dn,
    output logic [NUM_LOOPS-1:0] pump_hiz,
    output logic [NUM_LOOPS-1:0] icp_high,
    output logic                 fastlock_sw,
    output logic                 stat_out
);
    logic [NUM_LOOPS-1:0] rst_mask;
    logic [NUM_LOOPS-1:0] ld;

    assign rst_mask = reset_mask(stat_sel);

    for (genvar i = 0; i < NUM_LOOPS; i++) begin : g_loop
        pfd_state_t st;
        logic       act;
        logic       kill;
        logic       locked;

        assign kill = pwrdn[i] | rst_mask[i];
        assign act  = st.up | st.dn;

        pfd_detector u_det (
            .clk   (clk),
            .rst   (rst),
            .clear (kill),
            .ref_p (ref_pls[i]),
            .fb_p  (fb_pls[i]),
            .st    (st)
        );

        pfd_lock_mon #(.LOCK_WIN(LOCK_WIN), .LCW(LCW)) u_lock (
            .clk    (clk),
            .rst    (rst),
            .clear  (kill),
            .active (act),
            .need   (lock_need),
            .locked (locked)
        );

        assign ld[i] = locked & ~act & ~kill;

        pfd_pump_ctrl u_pump (
            .clk     (clk),
            .rst     (rst),
            .st      (st),
            .pol_pos (pol_pos[i]),
            .hiz_req (force_hiz[i] | kill),
            .cur_hi  (cur_hi[i]),
            .up_o    (pump_up[i]),
            .dn_o    (pump_dn[i]),
            .hiz_o   (pump_hiz[i]),
            .icp_o   (icp_high[i])
        );
    end

    assign fastlock_sw = (stat_sel == ST_FAST) & icp_high[1];

    pfd_stat_mux u_mux (
        .sel     (stat_sel),
        .ld      (ld),
        .ref_p   (ref_pls),
        .fb_p    (fb_pls),
        .fast_sw (fastlock_sw),
        .o       (stat_out)
    );
endmodule

// File: rtl/dual_pfd_ctrl_chk.sv
module dual_pfd_ctrl_chk
    import pfd_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LOOPS-1:0] pwrdn,
    input logic [SEL_W-1:0]     stat_sel,
    input logic [NUM_LOOPS-1:0] pump_up,
    input logic [NUM_LOOPS-1:0] pump_dn,
    input logic [NUM_LOOPS-1:0] pump_hiz,
    input logic [NUM_LOOPS-1:0] icp_high,
    input logic                 fastlock_sw,
    input logic                 stat_out
);
    for (genvar i = 0; i < NUM_LOOPS; i++) begin : g_chk
        // R1
        both_release_chk: assert property (@(posedge clk) disable iff (rst)
            (pump_up[i] && pump_dn[i]) |=> (!pump_up[i] && !pump_dn[i]));
        // R3
        hiz_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            pump_hiz[i] |-> (!pump_up[i] && !pump_dn[i]));
        // R4
        icp_idle_chk: assert property (@(posedge clk) disable iff (rst)
            ((icp_high[i] != $past(icp_high[i])) && !$past(pump_hiz[i]))
                |-> $past(!pump_up[i] && !pump_dn[i]));
        // R10
        pwrdn_hiz_chk: assert property (@(posedge clk) disable iff (rst)
            pwrdn[i] |-> pump_hiz[i]);
    end

    // R8
    fast_pull_chk: assert property (@(posedge clk) disable iff (rst)
        fastlock_sw |-> !stat_out);
    // R9
    rst_code_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_sel == ST_RST_ALL) |-> (&pump_hiz && !stat_out));
endmodule

bind dual_pfd_ctrl dual_pfd_ctrl_chk u_chk (.*);

// File: tb/dual_pfd_ctrl_bench.sv
module dual_pfd_ctrl_bench;
    localparam int LCW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] ref_pls = '0, fb_pls = '0, pol_pos = '0, force_hiz = '0, cur_hi = '0, pwrdn = '0;
    logic [3:0] stat_sel = '0;
    logic [LCW-1:0] lock_need = 4'd3;
    logic [1:0] pump_up, pump_dn, pump_hiz, icp_high;
    logic fastlock_sw, stat_out;

    int n_run = 0, n_fail = 0;
    int cu, cd;
    bit done = 0;

    always #4 clk = ~clk;

    dual_pfd_ctrl #(.LOCK_WIN(4), .LCW(LCW)) u_dual_pfd_ctrl (
        .clk(clk), .rst(rst), .ref_pls(ref_pls), .fb_pls(fb_pls), .pol_pos(pol_pos),
        .force_hiz(force_hiz), .cur_hi(cur_hi), .pwrdn(pwrdn), .stat_sel(stat_sel),
        .lock_need(lock_need), .pump_up(pump_up), .pump_dn(pump_dn), .pump_hiz(pump_hiz),
        .icp_high(icp_high), .fastlock_sw(fastlock_sw), .stat_out(stat_out));

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // lead input pulses at step 0, lag input at step d; counts high samples
    task automatic run_pair(input int lp, input bit ref_leads, input int d);
        cu = 0; cd = 0;
        for (int s = 0; s < 12; s++) begin
            ref_pls[lp] = ref_leads ? (s == 0) : (s == d);
            fb_pls[lp]  = ref_leads ? (s == d) : (s == 0);
            step();
            cu += int'(pump_up[lp]);
            cd += int'(pump_dn[lp]);
        end
        ref_pls[lp] = 0; fb_pls[lp] = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(); step(); rst = 0; step();
        // reset state
        check("R1 reset up", pump_up, 0);
        check("R1 reset dn", pump_dn, 0);
        check("R4 reset icp", icp_high, 0);
        check("R6 reset stat", stat_out, 0);

        // R1 / R2 sweep: loops, polarity, lead side, lag 0..5
        for (int lp = 0; lp < 2; lp++)
            for (int pol = 0; pol < 2; pol++)
                for (int rl = 0; rl < 2; rl++)
                    for (int d = 0; d < 6; d++) begin
                        bit lead_up;
                        pol_pos[lp] = pol[0];
                        run_pair(lp, rl[0], d);
                        lead_up = (rl[0] == pol[0]);
                        check("R1/R2 up width", cu, lead_up ? d + 1 : 1);
                        check("R1/R2 dn width", cd, lead_up ? 1 : d + 1);
                    end
        pol_pos = 2'b11;

        // R1 repeated leading pulse keeps output high
        ref_pls[1] = 1; step(); ref_pls[1] = 0; step(); step();
        ref_pls[1] = 1; step(); ref_pls[1] = 0; step();
        check("R1 hold on second lead", pump_up[1], 1);
        fb_pls[1] = 1; step(); fb_pls[1] = 0; step();
        check("R1 release", pump_up[1], 0);

        // R3 forced tri-state keeps detector running
        force_hiz[1] = 1;
        ref_pls[1] = 1; step(); ref_pls[1] = 0; step();
        check("R3 hiz", pump_hiz[1], 1);
        check("R3 up muted", pump_up[1], 0);
        force_hiz[1] = 0; #1;
        check("R3 state kept", pump_up[1], 1);
        fb_pls[1] = 1; step(); fb_pls[1] = 0; step(); step();

        // R5 lock detect on loop 1
        rst = 1; step(); rst = 0; step();
        stat_sel = 4'd2;
        run_pair(1, 1, 3); run_pair(1, 1, 3);
        check("R5 not yet locked", stat_out, 0);
        run_pair(1, 1, 3);
        check("R5 locked", stat_out, 1);
        ref_pls[1] = 1; fb_pls[1] = 1; step(); ref_pls[1] = 0; fb_pls[1] = 0;
        check("R5 low during episode", stat_out, 0);
        step();
        check("R5 high when idle", stat_out, 1);

        // R7 combined
        stat_sel = 4'd3; #1;
        check("R7 one loop only", stat_out, 0);
        run_pair(0, 0, 1); run_pair(0, 0, 1); run_pair(0, 0, 1);
        check("R7 both locked", stat_out, 1);
        stat_sel = 4'd1; #1;
        check("R6 lock0 code", stat_out, 1);

        // R5 over-long episode drops lock
        run_pair(1, 1, 4);
        stat_sel = 4'd2; #1;
        check("R5 unlock long", stat_out, 0);
        stat_sel = 4'd3; #1;
        check("R7 unlock long", stat_out, 0);

        // R6 divider pass-through and unused codes
        for (int k = 0; k < 4; k++) begin
            stat_sel = 4'(4 + k);
            if (k < 2) ref_pls[k] = 1; else fb_pls[k - 2] = 1;
            #1; check("R6 divider pass high", stat_out, 1);
            ref_pls = 0; fb_pls = 0;
            #1; check("R6 divider pass low", stat_out, 0);
        end
        ref_pls = 2'b11; fb_pls = 2'b11;
        for (int k = 12; k < 16; k++) begin
            stat_sel = 4'(k); #1;
            check("R6 unused code low", stat_out, 0);
        end
        stat_sel = 4'd0; #1;
        check("R6 off code low", stat_out, 0);
        ref_pls = 0; fb_pls = 0;
        step(); step(); step();

        // R9 counter reset on loop 0 only
        stat_sel = 4'd9; step();
        check("R9 hiz loop0", pump_hiz[0], 1);
        check("R9 loop1 free", pump_hiz[1], 0);
        check("R9 stat low", stat_out, 0);
        ref_pls = 2'b11; step(); ref_pls = 0;
        check("R9 loop1 runs", pump_up[1], 1);
        stat_sel = 4'd0; step();
        check("R9 pulse discarded", pump_up[0], 0);
        check("R9 hiz released", pump_hiz[0], 0);
        fb_pls[1] = 1; step(); fb_pls[1] = 0; step();
        stat_sel = 4'd11; #1;
        check("R9 both hiz", pump_hiz, 3);
        stat_sel = 4'd10; #1;
        check("R9 loop1 code", pump_hiz, 2);
        stat_sel = 4'd0; step();

        // R10 powerdown
        run_pair(1, 1, 0); run_pair(1, 1, 0); run_pair(1, 1, 0);
        stat_sel = 4'd2; #1;
        check("R10 locked before", stat_out, 1);
        ref_pls[1] = 1; step(); ref_pls[1] = 0;
        pwrdn[1] = 1; #1;
        check("R10 hiz", pump_hiz[1], 1);
        check("R10 ld low", stat_out, 0);
        step(); pwrdn[1] = 0; step();
        check("R10 detector cleared", pump_up[1], 0);
        check("R10 lock cleared", stat_out, 0);

        // R4 / R8 current select handover and fastlock
        ref_pls[1] = 1; step(); ref_pls[1] = 0;
        cur_hi[1] = 1; step();
        check("R4 held while active", icp_high[1], 0);
        fb_pls[1] = 1; step(); fb_pls[1] = 0;
        check("R4 held both high", icp_high[1], 0);
        step();
        check("R4 held release edge", icp_high[1], 0);
        step();
        check("R4 applied when idle", icp_high[1], 1);
        check("R4 other loop", icp_high[0], 0);
        stat_sel = 4'd8; #1;
        check("R8 switch on", fastlock_sw, 1);
        check("R8 pulled low", stat_out, 0);
        cur_hi[1] = 0; step();
        check("R4 cleared", icp_high[1], 0);
        check("R8 switch off", fastlock_sw, 0);
        check("R8 released", stat_out, 1);
        cur_hi[1] = 1; step(); step();
        stat_sel = 4'd2; #1;
        check("R8 other code", fastlock_sw, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule